// File: doc/BRIEF.md
# Gated Event Interrupt Status Controller

This block collects six single-cycle hardware event pulses from a paged-flash data-processing engine and turns them into software-visible status and a single level-sensitive interrupt line. Each event has two independent mask bits. The capture mask decides whether a pulse is recorded in the sticky status register at all. The signal mask decides whether a recorded bit drives the interrupt output.

Software reaches the three registers over a simple 32-bit register bus. That bus has a write strobe, a byte address and combinational read data. Software reads the status register and clears bits by writing ones to them. Writing back the value just read therefore clears exactly the bits it saw. With the signal mask at zero, software can still poll the status register, because capture does not depend on the signal mask.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset, the status, capture-mask and signal-mask registers all read zero, and `irq_out` is low.
- R2: An event pulse on `evt_pulse[i]` sets status bit i at the next clock edge only if capture-mask bit i is one. The status bits are assigned as follows: bit 0 transfer done, bit 1 main-area DMA, bit 2 spare-area DMA, bit 3 ECC failure, bit 4 moved to spare, bit 5 moved to main.
- R3: A status bit that has been set stays set after its pulse ends. It also stays set when its capture-mask bit is later cleared.
- R4: A bus write to the status register clears every status bit whose `reg_wdata` bit is one. Status bits whose `reg_wdata` bit is zero keep their value.
- R5: If a captured pulse and a clear of the same bit occur in the same cycle, the bit ends up at one. Other bits cleared by that same write still clear.
- R6: `irq_out` is registered. It is high one cycle after any bit of (status AND signal mask) is one, and low one cycle after that AND becomes zero.
- R7: With the signal mask at zero, `irq_out` stays low while status bits are still captured and readable.
- R8: The status register is at address 0x04, the capture mask at 0x08 and the signal mask at 0x0C. Both masks read back the value written to bits 5:0.
- R9: Bits 31:6 of every register read as zero, and writes to them have no effect.
- R10: Reads of any other address, including unaligned ones, return zero. Writes to them change no register.
- R11: Writing a one to a status bit that is already zero leaves it at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 6 | Event pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench pulses an event in the same cycle that software clears the same bit. A design that lets the clear win would lose that event, and the status would read zero instead of 0x02. It checks that a pulse on a bit whose capture mask is off leaves no trace, and that clearing the capture mask does not erase an event already recorded. A design that ANDed the enable into the held state would fail there. It also times `irq_out` against the registered path, checking that the line is still low in the cycle the status bit appears and still high in the cycle the clear lands. Further checks show that a zero signal mask silences the line but not capture, and that unmapped and unaligned addresses neither read nor write anything.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int EVT_N  = 6;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAPM = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SIGM = 8'h0C;

    localparam int BIT_XFER_DONE = 0;
    localparam int BIT_MAIN_DMA  = 1;
    localparam int BIT_SPARE_DMA = 2;
    localparam int BIT_ECC_FAIL  = 3;
    localparam int BIT_TO_SPARE  = 4;
    localparam int BIT_TO_MAIN   = 5;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_CAPM,
        SEL_SIGM
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic capm;
        logic sigm;
    } wr_stb_t;

    function automatic reg_sel_e f_decode(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] o_stat,
        input logic [ADDR_W-1:0] o_capm,
        input logic [ADDR_W-1:0] o_sigm
    );
        if (a == o_stat)      return SEL_STAT;
        else if (a == o_capm) return SEL_CAPM;
        else if (a == o_sigm) return SEL_SIGM;
        else                  return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_pkg::*;
#(
    parameter int                AW     = ADDR_W,
    parameter logic [AW-1:0]     A_STAT = OFS_STAT,
    parameter logic [AW-1:0]     A_CAPM = OFS_CAPM,
    parameter logic [AW-1:0]     A_SIGM = OFS_SIGM
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    output reg_sel_e      sel,
    output wr_stb_t       stb
);

    always_comb begin
        sel = f_decode(addr, A_STAT, A_CAPM, A_SIGM);
        stb = '0;
        if (wr) begin
            unique case (sel)
                SEL_STAT: stb.stat = 1'b1;
                SEL_CAPM: stb.capm = 1'b1;
                SEL_SIGM: stb.sigm = 1'b1;
                default:  stb      = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = irq_pkg::EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = irq_pkg::EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] cap_en,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic set_i;
        logic clr_i;
        assign set_i = evt[i] & cap_en[i];
        assign clr_i = clr_we & clr_mask[i];
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= 1'b0;
            else if (set_i) q[i] <= 1'b1;
            else if (clr_i) q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int W = irq_pkg::EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] sig_en,
    output logic         irq
);

    logic req;
    assign req = |(stat & sig_en);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= req;
    end

endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
    import irq_pkg::*;
#(
    parameter int NEVT = EVT_N,
    parameter int DW   = REG_W,
    parameter int AW   = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NEVT-1:0] evt_pulse,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);

    localparam int PAD_W = DW - NEVT;

    reg_sel_e        sel;
    wr_stb_t         stb;
    logic [NEVT-1:0] stat_q;
    logic [NEVT-1:0] capm_q;
    logic [NEVT-1:0] sigm_q;
    logic [NEVT-1:0] wlow;

    assign wlow = reg_wdata[NEVT-1:0];

    irq_reg_decode #(.AW(AW)) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .sel  (sel),
        .stb  (stb)
    );

    irq_mask_reg #(.W(NEVT)) u_capm (
        .clk (clk), .rst (rst), .we (stb.capm), .d (wlow), .q (capm_q)
    );

    irq_mask_reg #(.W(NEVT)) u_sigm (
        .clk (clk), .rst (rst), .we (stb.sigm), .d (wlow), .q (sigm_q)
    );

    irq_status_bank #(.W(NEVT)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .cap_en   (capm_q),
        .clr_we   (stb.stat),
        .clr_mask (wlow),
        .q        (stat_q)
    );

    irq_line_gen #(.W(NEVT)) u_line (
        .clk    (clk),
        .rst    (rst),
        .stat   (stat_q),
        .sig_en (sigm_q),
        .irq    (irq_out)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT: reg_rdata = {{PAD_W{1'b0}}, stat_q};
            SEL_CAPM: reg_rdata = {{PAD_W{1'b0}}, capm_q};
            SEL_SIGM: reg_rdata = {{PAD_W{1'b0}}, sigm_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_evt_ctrl_chk.sv
module irq_evt_ctrl_chk
    import irq_pkg::*;
#(
    parameter int NEVT = EVT_N,
    parameter int DW   = REG_W,
    parameter int AW   = ADDR_W
) (
    input logic            clk,
    input logic            rst,
    input logic [NEVT-1:0] evt_pulse,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   reg_rdata,
    input logic            irq_out,
    input logic [NEVT-1:0] stat_q,
    input logic [NEVT-1:0] capm_q,
    input logic [NEVT-1:0] sigm_q
);

    logic [NEVT-1:0] cap_now;
    logic            clr_now;
    assign cap_now = evt_pulse & capm_q;
    assign clr_now = reg_wr && (reg_addr == OFS_STAT);

    AST_RISE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~$past(stat_q) & ~$past(cap_now)) == '0);  // R2

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_q) & ~stat_q & ~($past(clr_now) ? $past(reg_wdata[NEVT-1:0]) : '0)) == '0);  // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cap_now != '0) |=> ((stat_q & $past(cap_now)) == $past(cap_now)));  // R5

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
        (|(stat_q & sigm_q)) |=> irq_out);  // R6

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
        !(|(stat_q & sigm_q)) |=> !irq_out);  // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sigm_q == '0) |=> !irq_out);  // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DW-1:NEVT] == '0);  // R9

endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk #(.NEVT(NEVT), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .stat_q    (stat_q),
    .capm_q    (capm_q),
    .sigm_q    (sigm_q)
);

// File: tb/tb_irq_evt_ctrl.sv
module tb_irq_evt_ctrl;

    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_CAPM = 8'h08;
    localparam logic [7:0] A_SIGM = 8'h0C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  evt_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irq_evt_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        bus_write(A_STAT, 32'h3F);
        bus_write(A_CAPM, 32'h0);
        bus_write(A_SIGM, 32'h0);
        idle(2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_STAT, v); chk("R1 status after reset", v, 0);
        bus_read(A_CAPM, v); chk("R1 capture mask after reset", v, 0);
        bus_read(A_SIGM, v); chk("R1 signal mask after reset", v, 0);
        chk("R1 irq after reset", {31'b0, irq_out}, 0);
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h2A);
        bus_write(A_SIGM, 32'h15);
        bus_read(A_CAPM, v); chk("R8 capture mask readback", v, 32'h2A);
        bus_read(A_SIGM, v); chk("R8 signal mask readback", v, 32'h15);
        bus_write(A_SIGM, 32'hFFFF_FFFF);
        bus_read(A_SIGM, v); chk("R9 signal mask upper bits", v, 32'h3F);
        bus_write(A_CAPM, 32'hFFFF_FFC0);
        bus_read(A_CAPM, v); chk("R9 capture mask upper-only write", v, 0);
        clear_all();
    endtask

    task automatic t_gate();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h05);
        pulse(6'h3F);
        bus_read(A_STAT, v); chk("R2 only enabled bits captured", v, 32'h05);
        bus_write(A_STAT, v);
        bus_read(A_STAT, v); chk("R4 write back of read value clears", v, 0);
        clear_all();
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h3F);
        pulse(6'h08);
        idle(5);
        bus_read(A_STAT, v); chk("R3 ECC failure bit held", v, 32'h08);
        bus_write(A_CAPM, 32'h0);
        bus_read(A_STAT, v); chk("R3 held after capture mask cleared", v, 32'h08);
        bus_write(A_STAT, 32'h37);
        bus_read(A_STAT, v); chk("R4 zero bit in write keeps status", v, 32'h08);
        bus_write(A_STAT, 32'h08);
        bus_read(A_STAT, v); chk("R4 one bit in write clears status", v, 0);
        bus_write(A_STAT, 32'h3F);
        bus_read(A_STAT, v); chk("R11 writing ones never sets status", v, 0);
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h3F);
        pulse(6'h10);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h12;
        evt_pulse = 6'h02;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
        bus_read(A_STAT, v); chk("R5 set beats clear, other bit clears", v, 32'h02);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h3F);
        bus_write(A_SIGM, 32'h01);
        pulse(6'h04);
        idle(2);
        chk("R6 unsignalled bit leaves irq low", {31'b0, irq_out}, 0);
        pulse(6'h01);
        chk("R6 irq not yet high in capture cycle", {31'b0, irq_out}, 0);
        @(negedge clk);
        chk("R6 irq high one cycle later", {31'b0, irq_out}, 1);
        bus_write(A_STAT, 32'h01);
        chk("R6 irq still high in clear cycle", {31'b0, irq_out}, 1);
        @(negedge clk);
        chk("R6 irq low one cycle after clear", {31'b0, irq_out}, 0);
        bus_read(A_STAT, v); chk("R6 other bit left latched", v, 32'h04);
        clear_all();
    endtask

    task automatic t_masked();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h01);
        pulse(6'h01);
        idle(3);
        chk("R7 irq low with zero signal mask", {31'b0, irq_out}, 0);
        bus_read(A_STAT, v); chk("R7 transfer done still pollable", v, 32'h01);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(A_CAPM, 32'h3F);
        bus_write(A_SIGM, 32'h0F);
        pulse(6'h21);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'h0);
        bus_read(8'h00, v); chk("R10 read of 0x00 is zero", v, 0);
        bus_read(8'h05, v); chk("R10 unaligned read is zero", v, 0);
        bus_read(8'h10, v); chk("R10 read of 0x10 is zero", v, 0);
        bus_read(8'hFC, v); chk("R10 read of 0xFC is zero", v, 0);
        bus_read(A_STAT, v); chk("R10 status untouched by stray writes", v, 32'h21);
        bus_read(A_CAPM, v); chk("R10 capture mask untouched", v, 32'h3F);
        bus_read(A_SIGM, v); chk("R10 signal mask untouched", v, 32'h0F);
        clear_all();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_offsets();
        t_gate();
        t_sticky();
        t_set_wins();
        t_irq();
        t_masked();
        t_unmapped();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule